// File: doc/BRIEF.md
# Depth-Dependent Memory Clock Enable Generator

This block runs in the pixel clock domain and produces a one-cycle enable strobe at the memory access rate. The memory rate follows the pixel depth, so that memory bandwidth matches the rate at which pixels are consumed. One bit per pixel needs the least bandwidth, so it gets the slowest rate. Eight bits per pixel runs at the full pixel rate. A software override bit in the mode register forces the full rate for every depth, which speeds up screen updates at the cost of power. When the rotated-display flag is high, an externally supplied ratio code replaces the depth-based choice, and the override bit is ignored.

Downstream logic uses the strobe as a clock enable instead of a derived clock. A 3-bit counter produces the strobe. A new ratio is applied only when the counter wraps, so no memory cycle is ever cut short or stretched. The block also decodes the display mode from the colour/mono flag and the depth code, and it flags the single reserved combination.

Top module: `mclk_strobe_gen`

## Requirements
- R1: While `rst_sync` is high, `mclk_en` is low and the counter is held at zero. `mclk_en` is high in the first cycle in which `rst_sync` is low.
- R2: The depth code is taken from `mode_reg[7:6]` and the override bit from `mode_reg[5]`. Bits `mode_reg[4:0]` have no effect on the strobe.
- R3: When not rotated and the override bit is 0, the strobe period in pixel clocks depends on the depth code as follows: 8 for code 00, 4 for code 01, 2 for code 10 and 1 for code 11. Each pulse outside divide-by-1 is exactly one cycle wide.
- R4: When not rotated and the override bit is 1, `mclk_en` is high in every cycle, whatever the depth code.
- R5: When `rotate_en` is 1, the period is 2 to the power `rotate_ratio`, which gives 1, 2, 4 or 8 for codes 0 to 3. The override bit has no effect in this case.
- R6: When `color_sel` is 0 and the depth code is 11, `mode_rsvd` is 1 and the period is 1. `mode_rsvd` is 0 for every other combination.
- R7: `disp_mode` equals {`color_sel`, depth code}. Values 0 to 2 mean 2, 4 and 16 gray shades, 3 is reserved, and 4 to 7 mean 2, 4, 16 and 256 colours.
- R8: A change of the selected ratio takes effect only at a counter wrap. The period that is in progress completes at its old length, and the next period uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_sync | input | 1 | Synchronous reset, active high |
| mode_reg | input | 8 | Mode register: depth code in [7:6], full-rate override in [5] |
| color_sel | input | 1 | 1 = colour, 0 = monochrome |
| rotate_en | input | 1 | Rotated display active; the external ratio is used |
| rotate_ratio | input | 2 | log2 of the divide ratio used in rotated mode |
| mclk_en | output | 1 | One-cycle memory clock enable strobe |
| disp_mode | output | 3 | Decoded display mode {colour, depth} |
| mode_rsvd | output | 1 | Reserved monochrome mode selected |

## Verification
The assertions assume that every input is synchronous to `clk_pix` and is sampled only at its rising edge. They also assume that the ratio inputs can change in any cycle, including in the middle of a period, because the wrap-only rule must absorb such changes. The bench changes inputs only at falling edges and samples outputs at falling edges. Before it judges a steady-state period, it lets one full period pass after any mode change. The wrap test deliberately changes the ratio in the cycle of a pulse, so that it lands in the middle of a period.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  localparam int MODE_W   = 8;
  localparam int DEPTH_HI = 7;
  localparam int DEPTH_LO = 6;
  localparam int PERF_BIT = 5;
  localparam int DEPTH_W  = DEPTH_HI - DEPTH_LO + 1;
  localparam int CNT_W    = 3;
  localparam int L2_W     = $clog2(CNT_W + 1);

  typedef enum logic [2:0] {
    DM_GRAY2   = 3'd0,
    DM_GRAY4   = 3'd1,
    DM_GRAY16  = 3'd2,
    DM_RSVD    = 3'd3,
    DM_COL2    = 3'd4,
    DM_COL4    = 3'd5,
    DM_COL16   = 3'd6,
    DM_COL256  = 3'd7
  } disp_mode_e;

  // Fewer bits per pixel -> slower memory rate: log2(divide) = max_code - depth.
  function automatic logic [L2_W-1:0] depth_to_l2(input logic [DEPTH_W-1:0] depth);
    logic [DEPTH_W-1:0] top_code;
    top_code = '1;
    return L2_W'(top_code - depth);
  endfunction

  // Last counter value of a period of 2**l2 cycles.
  function automatic logic [CNT_W-1:0] l2_to_limit(input logic [L2_W-1:0] l2);
    return CNT_W'((1 << l2) - 1);
  endfunction
endpackage

// File: rtl/mclk_mode_decode.sv
module mclk_mode_decode
  import mclk_pkg::*;
(
  input  logic [MODE_W-1:0]  mode_reg,
  input  logic               color_sel,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               perf_o,
  output disp_mode_e         disp_mode_o,
  output logic               rsvd_o
);
  logic [PERF_BIT-1:0] unused_low_bits;

  assign unused_low_bits = mode_reg[PERF_BIT-1:0];
  assign depth_o         = mode_reg[DEPTH_HI:DEPTH_LO];
  assign perf_o          = mode_reg[PERF_BIT];
  assign disp_mode_o     = disp_mode_e'({color_sel, depth_o});
  assign rsvd_o          = (disp_mode_o == DM_RSVD);
endmodule

// File: rtl/mclk_ratio_select.sv
module mclk_ratio_select
  import mclk_pkg::*;
(
  input  logic [DEPTH_W-1:0] depth,
  input  logic               perf,
  input  logic               rsvd,
  input  logic               rotate_en,
  input  logic [L2_W-1:0]    rotate_ratio,
  output logic [L2_W-1:0]    req_l2
);
  always_comb begin
    if (rotate_en)        req_l2 = rotate_ratio;
    else if (perf || rsvd) req_l2 = '0;
    else                  req_l2 = depth_to_l2(depth);
  end
endmodule

// File: rtl/mclk_strobe_counter.sv
module mclk_strobe_counter
  import mclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [L2_W-1:0] req_l2,
  output logic            strobe,
  output logic            wrap_evt,
  output logic [L2_W-1:0] act_l2
);
  logic [CNT_W-1:0] cnt;

  assign wrap_evt = (cnt == l2_to_limit(act_l2));
  assign strobe   = ~rst & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || wrap_evt) begin
      cnt    <= '0;
      act_l2 <= req_l2;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mclk_strobe_gen.sv
module mclk_strobe_gen
  import mclk_pkg::*;
(
  input  logic        clk_pix,
  input  logic        rst_sync,
  input  logic [7:0]  mode_reg,
  input  logic        color_sel,
  input  logic        rotate_en,
  input  logic [1:0]  rotate_ratio,
  output logic        mclk_en,
  output logic [2:0]  disp_mode,
  output logic        mode_rsvd
);
  logic [DEPTH_W-1:0] depth;
  logic               perf;
  disp_mode_e         dmode;
  logic [L2_W-1:0]    req_l2;
  logic [L2_W-1:0]    act_l2;
  logic               wrap_evt;

  mclk_mode_decode u_dec (
    .mode_reg    (mode_reg),
    .color_sel   (color_sel),
    .depth_o     (depth),
    .perf_o      (perf),
    .disp_mode_o (dmode),
    .rsvd_o      (mode_rsvd)
  );

  mclk_ratio_select u_sel (
    .depth        (depth),
    .perf         (perf),
    .rsvd         (mode_rsvd),
    .rotate_en    (rotate_en),
    .rotate_ratio (rotate_ratio),
    .req_l2       (req_l2)
  );

  mclk_strobe_counter u_cnt (
    .clk      (clk_pix),
    .rst      (rst_sync),
    .req_l2   (req_l2),
    .strobe   (mclk_en),
    .wrap_evt (wrap_evt),
    .act_l2   (act_l2)
  );

  assign disp_mode = dmode;
endmodule

// File: rtl/mclk_strobe_chk.sv
module mclk_strobe_chk
  import mclk_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            mclk_en,
  input logic [2:0]      disp_mode,
  input logic            mode_rsvd,
  input logic [L2_W-1:0] act_l2,
  input logic            wrap_evt
);
  logic [CNT_W:0] gap;
  logic [CNT_W:0] prd;
  logic           seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      prd  <= '0;
      seen <= 1'b0;
    end else if (mclk_en) begin
      gap  <= (CNT_W+1)'(1);
      prd  <= (CNT_W+1)'(1 << act_l2);
      seen <= 1'b1;
    end else begin
      gap  <= gap + 1'b1;
    end
  end

  // R1: first cycle out of reset carries a pulse
  a_r1_first_pulse: assert property (@(posedge clk) $fell(rst) |-> mclk_en);

  // R3/R5: spacing between pulses matches the ratio active when the period began
  a_r3_period: assert property (@(posedge clk) disable iff (rst)
    (mclk_en && seen) |-> (gap == prd));

  // R4: a ratio of one keeps the strobe continuously high
  a_r4_full_rate: assert property (@(posedge clk) disable iff (rst)
    (act_l2 == '0) |-> mclk_en);

  // R6: the reserved flag agrees with the decoded mode
  a_r6_rsvd_mode: assert property (@(posedge clk) disable iff (rst)
    mode_rsvd |-> (disp_mode == 3'd3));

  // R8: the active ratio moves only after a wrap
  a_r8_wrap_only: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_l2) && !$past(rst)) |-> $past(wrap_evt));
endmodule

bind mclk_strobe_gen mclk_strobe_chk u_chk (
  .clk       (clk_pix),
  .rst       (rst_sync),
  .mclk_en   (mclk_en),
  .disp_mode (disp_mode),
  .mode_rsvd (mode_rsvd),
  .act_l2    (act_l2),
  .wrap_evt  (wrap_evt)
);

// File: tb/test_mclk_strobe_gen.sv
`timescale 1ns/1ps
module test_mclk_strobe_gen;
  logic       clk_pix = 1'b0;
  logic       rst_sync = 1'b1;
  logic [7:0] mode_reg = 8'h00;
  logic       color_sel = 1'b1;
  logic       rotate_en = 1'b0;
  logic [1:0] rotate_ratio = 2'd0;
  logic       mclk_en;
  logic [2:0] disp_mode;
  logic       mode_rsvd;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_pix = ~clk_pix;

  mclk_strobe_gen i_mclk_strobe_gen (
    .clk_pix(clk_pix), .rst_sync(rst_sync), .mode_reg(mode_reg),
    .color_sel(color_sel), .rotate_en(rotate_en), .rotate_ratio(rotate_ratio),
    .mclk_en(mclk_en), .disp_mode(disp_mode), .mode_rsvd(mode_rsvd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync_pulse();
    int i = 0;
    while (!mclk_en && i < 64) begin @(negedge clk_pix); i++; end
  endtask

  task automatic measure(output int p);
    p = 0;
    do begin @(negedge clk_pix); p++; end while (!mclk_en && p < 64);
  endtask

  task automatic steady_period(output int p);
    int d;
    sync_pulse();
    measure(d);
    measure(p);
  endtask

  function automatic logic [7:0] mk_mode(input logic [1:0] d, input logic pf, input logic [4:0] lo);
    return {d, pf, lo};
  endfunction

  task automatic t_reset();
    int p;
    @(negedge clk_pix); mode_reg = mk_mode(2'b00, 1'b0, 5'd0); color_sel = 1'b1;
    repeat (3) @(negedge clk_pix);
    #1 chk(mclk_en == 1'b0, "R1 low in reset", mclk_en, 0);
    @(negedge clk_pix); rst_sync = 1'b0;
    #1 chk(mclk_en == 1'b1, "R1 first pulse", mclk_en, 1);
    @(negedge clk_pix);
    chk(mclk_en == 1'b0, "R3 one-cycle pulse", mclk_en, 0);
    measure(p);
    p = 0; measure(p);
    chk(p == 8, "R1 period after reset", p, 8);
  endtask

  task automatic t_depths(input logic col);
    int p;
    for (int d = 0; d < 4; d++) begin
      @(negedge clk_pix);
      color_sel = col; rotate_en = 1'b0;
      mode_reg = mk_mode(2'(d), 1'b0, 5'd0);
      #1 chk(disp_mode == {col, 2'(d)}, "R7 decode", disp_mode, {col, 2'(d)});
      chk(mode_rsvd == (!col && d == 3), "R6 flag", mode_rsvd, (!col && d == 3));
      steady_period(p);
      if (!col && d == 3) chk(p == 1, "R6 reserved rate", p, 1);
      else chk(p == (8 >> d), "R3 depth ratio", p, 8 >> d);
    end
  endtask

  task automatic t_fields();
    int p;
    @(negedge clk_pix); color_sel = 1'b1; mode_reg = mk_mode(2'b01, 1'b0, 5'b10101);
    steady_period(p);
    chk(p == 4, "R2 low bits ignored a", p, 4);
    @(negedge clk_pix); mode_reg = mk_mode(2'b01, 1'b0, 5'b11111);
    steady_period(p);
    chk(p == 4, "R2 low bits ignored b", p, 4);
  endtask

  task automatic t_perf();
    int p;
    for (int d = 0; d < 3; d++) begin
      @(negedge clk_pix); mode_reg = mk_mode(2'(d), 1'b1, 5'd0);
      steady_period(p);
      chk(p == 1, "R4 override full rate", p, 1);
    end
  endtask

  task automatic t_rotate();
    int p;
    for (int r = 0; r < 4; r++) begin
      @(negedge clk_pix);
      rotate_en = 1'b1; rotate_ratio = 2'(r);
      mode_reg = mk_mode(2'b00, 1'b1, 5'd0);
      steady_period(p);
      chk(p == (1 << r), "R5 rotated ratio", p, 1 << r);
    end
    @(negedge clk_pix); rotate_en = 1'b0;
  endtask

  task automatic t_wrap();
    int p;
    @(negedge clk_pix); color_sel = 1'b1; mode_reg = mk_mode(2'b00, 1'b0, 5'd0);
    steady_period(p);
    // now at a pulse cycle of a divide-by-8 period: switch to divide-by-1
    mode_reg = mk_mode(2'b11, 1'b0, 5'd0);
    measure(p);
    chk(p == 8, "R8 old period completes", p, 8);
    measure(p);
    chk(p == 1, "R8 new period applies", p, 1);
  endtask

  initial begin
    t_reset();
    t_depths(1'b1);
    t_depths(1'b0);
    t_fields();
    t_perf();
    t_rotate();
    t_wrap();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_pix);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule